// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block gathers up to 64 device interrupt request lines into one global pending vector and steers them to up to four processors. Each processor owns a mask register that selects which pending requests it accepts; the AND of that mask with the pending vector is held as the processor's routed vector. A processor's interrupt line is a level that stays high while any bit of its routed vector is set.

Device logic sets or clears individual pending bits through two strobe vectors. Software sees the block through a 64-bit register port with single-cycle read and write strobes. It can read the pending, mask and routed registers and write the mask registers. Read data appears one cycle after the strobe, and an access that breaks the access rules raises a one-cycle error pulse. Because the routed vector is rebuilt on the same clock edge as any mask write or pending change, a mask write that exposes a pending request raises the line, and one that hides the last routed bit drops it.

Top module: `dev_irq_router`

## Requirements
- R1: For every processor c, the routed register equals mask c AND the pending vector after every clock edge. It reads as that value.
- R2: A 1 on req_set bit n sets pending bit n at the next edge. Every processor whose mask has bit n set then sees its routed bit n set.
- R3: A 1 on req_clr bit n clears a pending bit n. A clear of a bit that is not pending, with no set on that bit, leaves the vector unchanged and pulses spur_clr high for one cycle after the edge.
- R4: When req_set and req_clr both hold bit n in the same cycle, bit n ends up pending.
- R5: A mask write that enables a pending bit raises that processor's line. A mask write that removes its last routed bit lowers the line.
- R6: cpu_irq[c] equals the OR of routed register c as it stood one clock earlier.
- R7: The register index is reg_addr shifted right by 6. Index 1 is the pending vector. Indices 2 to 5 are the masks of processors 0 to 3. Indices 8 to 11 are the routed vectors of processors 0 to 3. reg_rdata holds the read value from the edge that sampled reg_rd.
- R8: reg_err pulses one cycle after an access when any of these holds: reg_size is not 3 (64-bit), reg_addr[2:0] is not zero, or the index is unmapped. A write to the pending or routed registers also pulses reg_err. A faulty read returns zero, and a faulty write changes no register.
- R9: After reset all registers read zero, and cpu_irq, spur_clr, reg_err and reg_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | NUM_SRC | Per-line set strobes for the pending vector |
| req_clr | input | NUM_SRC | Per-line clear strobes for the pending vector |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_size | input | 2 | log2 of access size in bytes; 3 is the only legal value |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after reg_rd |
| reg_err | output | 1 | One-cycle pulse for an illegal access |
| spur_clr | output | 1 | One-cycle pulse for a clear of a non-pending line |
| cpu_irq | output | NUM_CPU | Level interrupt per processor |

## Verification
On every cycle the assertions check several properties. The routed registers must equal mask AND pending, and set strobes must stick. A clear without a set must empty its bit and flag a spurious clear when nothing was pending. Each line must follow the previous cycle's routed OR, and a malformed access size must raise an error. Only the bench's scenarios can show the address decode of each register. They also show the zeroed read data of faulty reads, that rejected writes leave masks untouched, and the rise and fall of a line caused by mask writes against a live pending set.

// File: rtl/dev_irq_router.sv
module dev_irq_router #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_set,
  input  logic [NUM_SRC-1:0] req_clr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [1:0]         reg_size,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               reg_err,
  output logic               spur_clr,
  output logic [NUM_CPU-1:0] cpu_irq
);
  localparam int IDX_W     = ADDR_W - 6;
  localparam int IDX_PEND  = 1;
  localparam int IDX_MASK  = 2;
  localparam int IDX_ROUTE = 8;

  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [NUM_SRC-1:0] mask_q   [NUM_CPU];
  logic [NUM_SRC-1:0] mask_d   [NUM_CPU];
  logic [NUM_SRC-1:0] routed_q [NUM_CPU];
  logic [NUM_CPU*NUM_SRC-1:0] mask_flat, routed_flat;

  logic [NUM_CPU-1:0] hit_mask, hit_route;
  logic [63:0] rd_val;

  wire [IDX_W-1:0] idx   = reg_addr[ADDR_W-1:6];
  wire fmt_ok            = (reg_size == 2'd3) && (reg_addr[2:0] == 3'd0);
  wire hit_pend          = (idx == IDX_W'(IDX_PEND));
  wire mapped            = hit_pend | (|hit_mask) | (|hit_route);
  wire rd_ok             = reg_rd & fmt_ok & mapped;
  wire wr_ok             = reg_wr & fmt_ok & (|hit_mask);
  wire bad_acc           = (reg_rd & ~rd_ok) | (reg_wr & ~wr_ok);

  assign pend_d = (pend_q & ~req_clr) | req_set;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assign hit_mask[c]  = (idx == IDX_W'(IDX_MASK + c));
    assign hit_route[c] = (idx == IDX_W'(IDX_ROUTE + c));
    assign mask_d[c]    = (wr_ok && hit_mask[c]) ? reg_wdata[NUM_SRC-1:0] : mask_q[c];
    assign mask_flat[c*NUM_SRC +: NUM_SRC]   = mask_q[c];
    assign routed_flat[c*NUM_SRC +: NUM_SRC] = routed_q[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[c]   <= '0;
        routed_q[c] <= '0;
        cpu_irq[c]  <= 1'b0;
      end else begin
        mask_q[c]   <= mask_d[c];
        routed_q[c] <= mask_d[c] & pend_d;
        cpu_irq[c]  <= |routed_q[c];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_pend) rd_val = 64'(pend_q);
    for (int c = 0; c < NUM_CPU; c++) begin
      if (hit_mask[c])  rd_val = 64'(mask_q[c]);
      if (hit_route[c]) rd_val = 64'(routed_q[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      reg_rdata <= '0;
      reg_err   <= 1'b0;
      spur_clr  <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      reg_err  <= bad_acc;
      spur_clr <= |(req_clr & ~pend_q & ~req_set);
      if (reg_rd) reg_rdata <= rd_ok ? rd_val : '0;
    end
  end
endmodule

module dev_irq_router_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_SRC-1:0]         req_set,
  input logic [NUM_SRC-1:0]         req_clr,
  input logic [NUM_SRC-1:0]         pend_q,
  input logic [NUM_CPU*NUM_SRC-1:0] mask_flat,
  input logic [NUM_CPU*NUM_SRC-1:0] routed_flat,
  input logic [NUM_CPU-1:0]         cpu_irq,
  input logic                       spur_clr,
  input logic                       reg_err,
  input logic                       reg_rd,
  input logic                       reg_wr,
  input logic [1:0]                 reg_size
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    assert_routed_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
      routed_flat[c*NUM_SRC +: NUM_SRC] == (mask_flat[c*NUM_SRC +: NUM_SRC] & pend_q));
    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] == $past(|routed_flat[c*NUM_SRC +: NUM_SRC]));
  end

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_set != '0) |=> ((pend_q & $past(req_set)) == $past(req_set)));

  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_clr & ~req_set) != '0) |=> ((pend_q & $past(req_clr & ~req_set)) == '0));

  assert_spurious_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_clr & ~pend_q & ~req_set) != '0) |=> spur_clr);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_set & req_clr) != '0) |=> ((pend_q & $past(req_set & req_clr)) != '0));

  assert_bad_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rd || reg_wr) && reg_size != 2'd3) |=> reg_err);
endmodule

bind dev_irq_router dev_irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
  .pend_q(pend_q), .mask_flat(mask_flat), .routed_flat(routed_flat),
  .cpu_irq(cpu_irq), .spur_clr(spur_clr), .reg_err(reg_err),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_size(reg_size)
);

// File: tb/tb_dev_irq_router.sv
module tb_dev_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req_set = '0, req_clr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [1:0]  reg_size = 2'd3;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        reg_err, spur_clr;
  logic [3:0]  cpu_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [63:0] m_pend;
  logic [63:0] m_mask [4];

  always #2 clk = ~clk;

  dev_irq_router dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .spur_clr(spur_clr), .cpu_irq(cpu_irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_err(bit rd, bit wr, logic [11:0] a, logic [1:0] sz);
    int i = int'(a >> 6);
    bit fmt = (sz == 2'd3) && (a[2:0] == 3'd0);
    bit mhit = (i >= 2 && i <= 5);
    bit mapped = (i == 1) || mhit || (i >= 8 && i <= 11);
    return (rd && !(fmt && mapped)) || (wr && !(fmt && mhit));
  endfunction

  function automatic logic [63:0] exp_read(logic [11:0] a, logic [1:0] sz);
    int i = int'(a >> 6);
    if (exp_err(1'b1, 1'b0, a, sz)) return '0;
    if (i == 1) return m_pend;
    if (i >= 2 && i <= 5) return m_mask[i-2];
    return m_mask[i-8] & m_pend;
  endfunction

  task automatic step(string tag, logic [63:0] s, logic [63:0] c, bit rd, bit wr,
                      logic [11:0] a, logic [1:0] sz, logic [63:0] wd);
    logic [3:0]  e_irq;
    logic [63:0] e_rd;
    bit e_err, e_spur;
    @(negedge clk);
    req_set = s; req_clr = c; reg_rd = rd; reg_wr = wr;
    reg_addr = a; reg_size = sz; reg_wdata = wd;
    for (int k = 0; k < 4; k++) e_irq[k] = |(m_mask[k] & m_pend);
    e_rd   = rd ? exp_read(a, sz) : reg_rdata;
    e_err  = exp_err(rd, wr, a, sz);
    e_spur = |(c & ~m_pend & ~s);
    @(posedge clk);
    #1;
    m_pend = (m_pend & ~c) | s;
    if (wr && !e_err) m_mask[int'(a >> 6) - 2] = wd;
    chk({"R6 irq ", tag}, 64'(cpu_irq), 64'(e_irq));
    chk({"R3 spurious ", tag}, 64'(spur_clr), 64'(e_spur));
    chk({"R8 err ", tag}, 64'(reg_err), 64'(e_err));
    if (rd) chk({"R7 rdata ", tag}, reg_rdata, e_rd);
  endtask

  task automatic rd64(string tag, int idx);
    step(tag, '0, '0, 1'b1, 1'b0, 12'(idx << 6), 2'd3, '0);
  endtask

  task automatic wr64(string tag, int idx, logic [63:0] d);
    step(tag, '0, '0, 1'b0, 1'b1, 12'(idx << 6), 2'd3, d);
  endtask

  task automatic idle();
    step("idle", '0, '0, 1'b0, 1'b0, '0, 2'd3, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_pend = '0;
    for (int k = 0; k < 4; k++) m_mask[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 irq after reset", 64'(cpu_irq), 64'd0);
    chk("R9 rdata after reset", reg_rdata, 64'd0);
    chk("R9 err after reset", 64'(reg_err), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    rd64("R9 pending zero", 1);
    for (int k = 0; k < 4; k++) begin
      rd64("R9 mask zero", 2 + k);
      rd64("R9 routed zero", 8 + k);
    end

    wr64("R5 mask0", 2, (64'd1 << 5) | (64'd1 << 63));
    wr64("R5 mask2", 4, 64'd1 << 5);
    step("R2 set 5", 64'd1 << 5, '0, 1'b0, 1'b0, '0, 2'd3, '0);
    idle(); idle();
    chk("R2 irq cpu0,2 raised", 64'(cpu_irq), 64'b0101);
    rd64("R1 routed0", 8);
    chk("R1 routed0 value", reg_rdata, 64'd1 << 5);
    rd64("R1 routed1 empty", 9);
    chk("R1 routed1 value", reg_rdata, 64'd0);

    step("R4 set+clr 9", 64'd1 << 9, 64'd1 << 9, 1'b0, 1'b0, '0, 2'd3, '0);
    rd64("R4 pending", 1);
    chk("R4 bit 9 kept", reg_rdata & (64'd1 << 9), 64'd1 << 9);

    step("R3 spurious 40", '0, 64'd1 << 40, 1'b0, 1'b0, '0, 2'd3, '0);
    chk("R3 spurious pulse", 64'(spur_clr), 64'd1);
    rd64("R3 pending unchanged", 1);
    chk("R3 pending value", reg_rdata, (64'd1 << 5) | (64'd1 << 9));

    wr64("R5 mask1 enable pending 9", 3, 64'd1 << 9);
    idle(); idle();
    chk("R5 cpu1 raised", 64'(cpu_irq[1]), 64'd1);
    wr64("R5 mask0 drop 5", 2, 64'd1 << 63);
    idle(); idle();
    chk("R5 cpu0 lowered", 64'(cpu_irq[0]), 64'd0);

    step("R3 clear 5", '0, 64'd1 << 5, 1'b0, 1'b0, '0, 2'd3, '0);
    idle(); idle();
    chk("R3 cpu2 lowered", 64'(cpu_irq[2]), 64'd0);

    step("R8 short read", '0, '0, 1'b1, 1'b0, 12'(1 << 6), 2'd2, '0);
    chk("R8 short read zero", reg_rdata, 64'd0);
    step("R8 misaligned", '0, '0, 1'b1, 1'b0, 12'((2 << 6) | 4), 2'd3, '0);
    rd64("R8 unmapped 7", 7);
    wr64("R8 write pending", 1, '1);
    wr64("R8 write routed", 9, '1);
    step("R8 short write", '0, '0, 1'b0, 1'b1, 12'(5 << 6), 2'd1, '1);
    rd64("R8 mask3 untouched", 5);
    chk("R8 mask3 value", reg_rdata, 64'd0);
    rd64("R8 pending untouched", 1);
    chk("R8 pending value", reg_rdata, 64'd1 << 9);

    for (int n = 0; n < 4000; n++) begin
      logic [63:0] s, c, wd;
      int sel, idx;
      s = ($urandom % 3 == 0) ? (64'd1 << ($urandom % 64)) : '0;
      c = ($urandom % 3 == 0) ? (64'd1 << ($urandom % 64)) : '0;
      if ($urandom % 16 == 0) c = c | s;
      sel = $urandom % 8;
      idx = $urandom % 13;
      wd = {$urandom, $urandom} & {$urandom, $urandom};
      if (sel == 0)
        step("R1 rand mask write", s, c, 1'b0, 1'b1, 12'((2 + ($urandom % 4)) << 6), 2'd3, wd);
      else if (sel < 3)
        step("R1 rand read", s, c, 1'b1, 1'b0, 12'(idx << 6), 2'd3, '0);
      else if (sel == 3)
        step("R8 rand access", s, c, 1'($urandom), 1'($urandom), 12'($urandom), 2'($urandom), wd);
      else
        step("R2 rand req", s, c, 1'b0, 1'b0, '0, 2'd3, '0);
    end
    for (int k = 0; k < 4; k++) rd64("R1 final routed", 8 + k);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule